// File: doc/BRIEF.md
# Calendar Alarm Comparator

The block watches the calendar and time-of-day value produced by a clock core and compares it with a stored alarm value. Each of the seven fields (year, month, day of month, day of week, hour, minute, second) carries its own compare enable, so an alarm can fire once a minute, once a day, on a weekday, or at one exact moment. A field whose enable is clear counts as matching. A global arm bit gates the whole comparison, and the block reports that arm state on a status output.

Comparison is evaluated on the cycle in which the clock core pulses its one-second tick. A hit gives a one-cycle raw interrupt pulse. The interrupt output combines that pulse with an enable level and a force level. While the comparator is armed, the stored alarm value and field enables are frozen, and any write to them is dropped.

Top module: `alarm_match`

## Requirements
- R1: After reset, raw_o, irq_o and armed_o are 0, and alarm_val_o and alarm_fen_o are all zero.
- R2: A cycle with cfg_we_i high while armed_o is 0 loads cfg_val_i into alarm_val_o and cfg_fen_i into alarm_fen_o, visible the cycle after. This applies when arm_we_i sets the arm bit in that same cycle.
- R3: While armed_o is 1, cfg_we_i has no effect on alarm_val_o or alarm_fen_o.
- R4: A cycle with arm_we_i high loads arm_i into the arm bit, visible on armed_o the cycle after.
- R5: The time is packed as {year[40:29], month[28:25], day[24:20], day-of-week[19:17], hour[16:12], minute[11:6], second[5:0]}. Enable bit k selects the field with index k, where second=0, minute=1, hour=2, day-of-week=3, day=4, month=5 and year=6. When armed, a tick cycle in which every enabled field equals its alarm field makes raw_o 1 for the following cycle. A disabled field never blocks a match.
- R6: While disarmed, raw_o stays 0. Disarming forgets any earlier match.
- R7: With at least one field enabled, consecutive ticks that all match give only one raw_o pulse. A new pulse needs a tick that does not match, followed by a tick that matches again.
- R8: Armed with no field enabled, every tick gives a raw_o pulse.
- R9: irq_o = (raw_o AND irq_en_i) OR irq_force_i, evaluated combinationally.
- R10: raw_o is 1 only in the cycle after a tick_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick from the clock core; now_i is valid when it is high |
| now_i | input | 41 | Live packed calendar value |
| cfg_we_i | input | 1 | Write strobe for the alarm value and field enables |
| cfg_val_i | input | 41 | Alarm value to load |
| cfg_fen_i | input | 7 | Per-field compare enables to load |
| arm_we_i | input | 1 | Write strobe for the arm bit |
| arm_i | input | 1 | Arm value to load |
| irq_en_i | input | 1 | Interrupt enable level |
| irq_force_i | input | 1 | Interrupt force level |
| armed_o | output | 1 | Matching currently armed |
| alarm_val_o | output | 41 | Stored alarm value |
| alarm_fen_o | output | 7 | Stored field enables |
| raw_o | output | 1 | Raw match pulse |
| irq_o | output | 1 | Masked and forced interrupt |

## Verification
The hardest case is the match that persists over several ticks. The first matching tick must pulse and the next must not. The pulse must then return once the time has left the match and come back, and that behaviour changes when every field enable is clear. The stimulus holds a matching time over back-to-back ticks, steps one second away and returns. It then repeats the run with no field enabled. A write attempted while armed, followed by a readback of the stored fields, shows that the freeze holds.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int NUM_FIELDS = 7;
  // index order: sec, min, hour, dotw, day, month, year
  localparam int FIELD_W [NUM_FIELDS] = '{6, 6, 5, 3, 5, 4, 12};

  function automatic int field_lsb(int idx);
    int s = 0;
    for (int k = 0; k < idx; k++) s += FIELD_W[k];
    return s;
  endfunction

  localparam int TIME_W = field_lsb(NUM_FIELDS);
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W = 6
) (
  input  logic [W-1:0] now_i,
  input  logic [W-1:0] alarm_i,
  input  logic         en_i,
  output logic         hit_o
);
  assign hit_o = !en_i || (now_i == alarm_i);
endmodule

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import alarm_match_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [TIME_W-1:0]     cfg_val_i,
  input  logic [NUM_FIELDS-1:0] cfg_fen_i,
  input  logic                  arm_we_i,
  input  logic                  arm_i,
  output logic                  arm_o,
  output logic [TIME_W-1:0]     val_o,
  output logic [NUM_FIELDS-1:0] fen_o
);
  logic                  arm_q;
  logic [TIME_W-1:0]     val_q;
  logic [NUM_FIELDS-1:0] fen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      val_q <= '0;
      fen_q <= '0;
    end else begin
      if (arm_we_i) arm_q <= arm_i;
      if (cfg_we_i && !arm_q) begin  // frozen while armed
        val_q <= cfg_val_i;
        fen_q <= cfg_fen_i;
      end
    end
  end

  assign arm_o = arm_q;
  assign val_o = val_q;
  assign fen_o = fen_q;

  assert_frozen_while_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(arm_q) |-> ($stable(val_q) && $stable(fen_q)));
endmodule

// File: rtl/alarm_trigger.sv
module alarm_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic armed_i,
  input  logic all_hit_i,
  input  logic any_en_i,
  output logic raw_o
);
  logic prev_q, raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      // no enabled field: each tick is a fresh match
      raw_q <= tick_i && armed_i && all_hit_i && (!prev_q || !any_en_i);
      if (!armed_i)    prev_q <= 1'b0;
      else if (tick_i) prev_q <= all_hit_i;
    end
  end

  assign raw_o = raw_q;

  assert_raw_after_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_q |-> $past(tick_i));
  assert_raw_needs_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_q |-> $past(armed_i));
  assert_no_retrigger_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && any_en_i && armed_i) |=> !raw_q);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_match_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [TIME_W-1:0]     now_i,
  input  logic                  cfg_we_i,
  input  logic [TIME_W-1:0]     cfg_val_i,
  input  logic [NUM_FIELDS-1:0] cfg_fen_i,
  input  logic                  arm_we_i,
  input  logic                  arm_i,
  input  logic                  irq_en_i,
  input  logic                  irq_force_i,
  output logic                  armed_o,
  output logic [TIME_W-1:0]     alarm_val_o,
  output logic [NUM_FIELDS-1:0] alarm_fen_o,
  output logic                  raw_o,
  output logic                  irq_o
);
  logic                  arm;
  logic [TIME_W-1:0]     val;
  logic [NUM_FIELDS-1:0] fen;
  logic [NUM_FIELDS-1:0] hit;
  logic                  raw;

  alarm_cfg_regs u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_val_i, .cfg_fen_i, .arm_we_i, .arm_i,
    .arm_o(arm), .val_o(val), .fen_o(fen)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int LSB = field_lsb(g);
    localparam int W   = FIELD_W[g];
    alarm_field_cmp #(.W(W)) u_cmp (
      .now_i(now_i[LSB +: W]), .alarm_i(val[LSB +: W]), .en_i(fen[g]), .hit_o(hit[g])
    );
  end

  alarm_trigger u_trig (
    .clk_i, .rst_ni, .tick_i, .armed_i(arm), .all_hit_i(&hit), .any_en_i(|fen), .raw_o(raw)
  );

  assign armed_o     = arm;
  assign alarm_val_o = val;
  assign alarm_fen_o = fen;
  assign raw_o       = raw;
  assign irq_o       = (raw && irq_en_i) || irq_force_i;

  assert_force_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_force_i |-> irq_o);
  assert_masked_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !irq_force_i) |-> !irq_o);
endmodule

// File: tb/alarm_match_tb_top.sv
module alarm_match_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic tick = 0, cfg_we = 0, arm_we = 0, arm_v = 0, irq_en = 0, irq_force = 0;
  logic [40:0] now = '0, cfg_val = '0;
  logic [6:0]  cfg_fen = '0;
  logic armed, raw, irq;
  logic [40:0] aval;
  logic [6:0]  afen;

  always #(CLK_P/2) clk = ~clk;

  alarm_match dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .now_i(now), .cfg_we_i(cfg_we),
    .cfg_val_i(cfg_val), .cfg_fen_i(cfg_fen), .arm_we_i(arm_we), .arm_i(arm_v),
    .irq_en_i(irq_en), .irq_force_i(irq_force), .armed_o(armed),
    .alarm_val_o(aval), .alarm_fen_o(afen), .raw_o(raw), .irq_o(irq)
  );

  typedef struct { logic raw; logic irq; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;
  logic m_arm = 0, m_prev = 0;
  logic [40:0] m_val = '0;
  logic [6:0]  m_fen = '0;

  function automatic logic [40:0] mk(int y, int mo, int d, int w, int h, int mi, int s);
    return {y[11:0], mo[3:0], d[4:0], w[2:0], h[4:0], mi[5:0], s[5:0]};
  endfunction

  function automatic logic model_hit(logic [40:0] t);
    logic ok = 1;
    if (m_fen[0] && t[5:0]   != m_val[5:0])   ok = 0;
    if (m_fen[1] && t[11:6]  != m_val[11:6])  ok = 0;
    if (m_fen[2] && t[16:12] != m_val[16:12]) ok = 0;
    if (m_fen[3] && t[19:17] != m_val[19:17]) ok = 0;
    if (m_fen[4] && t[24:20] != m_val[24:20]) ok = 0;
    if (m_fen[5] && t[28:25] != m_val[28:25]) ok = 0;
    if (m_fen[6] && t[40:29] != m_val[40:29]) ok = 0;
    return ok;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // driver: called at a negedge with inputs set; predicts outputs after the next edge
  task automatic drive(logic tk, string tag);
    logic h, r;
    tick = tk;
    h = model_hit(now);
    r = tk && m_arm && h && (!m_prev || m_fen == 0);
    q.push_back('{r, (r && irq_en) || irq_force, tag});
    if (cfg_we && !m_arm) begin m_val = cfg_val; m_fen = cfg_fen; end
    if (!m_arm) m_prev = 0; else if (tk) m_prev = h;
    if (arm_we) m_arm = arm_v;
    @(negedge clk);
    tick = 0; cfg_we = 0; arm_we = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({e.tag, " raw"}, 64'(raw), 64'(e.raw));
      chk({e.tag, " irq"}, 64'(irq), 64'(e.irq));
    end
  end

  logic done = 0;
  initial begin
    #(CLK_P*50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [40:0] a;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 raw", 64'(raw), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 armed", 64'(armed), 0);
    chk("R1 val", 64'(aval), 0);
    chk("R1 fen", 64'(afen), 0);

    a = mk(2024, 3, 15, 5, 10, 30, 45);
    cfg_val = a; cfg_fen = 7'b0000011; cfg_we = 1;
    drive(0, "R2 load");
    chk("R2 val", 64'(aval), 64'(a));
    chk("R2 fen", 64'(afen), 3);

    arm_we = 1; arm_v = 1;
    drive(0, "R4 arm");
    chk("R4 armed", 64'(armed), 1);

    cfg_val = mk(1, 1, 1, 1, 1, 1, 1); cfg_fen = 7'h7f; cfg_we = 1;
    drive(0, "R3 blocked");
    chk("R3 val", 64'(aval), 64'(a));
    chk("R3 fen", 64'(afen), 3);

    now = mk(2024, 3, 15, 5, 10, 30, 44);
    drive(1, "R5 mismatch");
    now = mk(1999, 7, 2, 1, 3, 30, 45);  // only sec/min enabled
    drive(1, "R5 match masked");
    drive(1, "R7 hold");
    drive(0, "R10 no tick");
    irq_en = 1;
    now = mk(1999, 7, 2, 1, 3, 30, 46);
    drive(1, "R7 leave");
    now = a;
    drive(1, "R7 reenter");
    irq_force = 1;
    drive(0, "R9 force");
    irq_force = 0;

    now = mk(2024, 3, 15, 5, 10, 30, 47);
    drive(1, "R6 leave");
    arm_we = 1; arm_v = 0;
    drive(0, "R4 disarm");
    chk("R4 disarmed", 64'(armed), 0);
    now = a;
    drive(1, "R6 disarmed tick");

    cfg_fen = 7'b0; cfg_val = a; cfg_we = 1; arm_we = 1; arm_v = 1;
    drive(0, "R2 load with arm");
    chk("R2 fen zero", 64'(afen), 0);
    for (int i = 0; i < 3; i++) begin
      now = mk(2030, 1, 1, 2, 0, 0, i);
      drive(1, "R8 every tick");
    end
    drive(0, "R8 idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule